// File: doc/BRIEF.md
# Trace Port Pin-Ownership Controller

This block holds the debug-side configuration for a trace output port and turns it into pin ownership. A debug host writes a three-bit word that holds an enable flag and a two-bit mode. From that word the block decides which of six shared package pins are given to the trace function and which stay with general-purpose I/O. The six pins are a single-wire output, a trace clock and four trace data lanes. The block also reports when the single-wire pin carries the JTAG data-out function instead.

The configuration lives in the power-on reset domain. A system reset neither clears it nor blocks host writes. This keeps a debugger session and its trace setup alive while the rest of the chip is held in reset.

The block also produces the clock for the trace port input. That clock stays low while trace is disabled. Once the enable flag is set, the clock waits a fixed number of bus-clock cycles (two by default). It then follows the bus clock through a gating stage whose enable changes only while the bus clock is low. Clearing the enable flag stops the trace clock after the current cycle. A later enable waits the full delay again. All pins are plain control signals and there is no streaming interface.

Top module: `trace_pin_ctrl`

## Requirements
- R1: While `por_n` is low, the configuration is held at zero. All `pin_trace` bits are 0 and `trace_clk` is 0.
- R2: When the enable flag (`wr_data[2]` as written) is 0, every `pin_trace` bit is 0 whatever the mode field `wr_data[1:0]` holds.
- R3: When enable is 1 and mode is 0, only `pin_trace[0]` (single-wire out) is 1. This is asynchronous trace.
- R4: When enable is 1 and mode is 1, `pin_trace[1]` (clock) and `pin_trace[2]` (data 0) are 1 and all other bits are 0.
- R5: When enable is 1 and mode is 2, bits 1 to 3 are 1 (clock, data 0 and 1). When mode is 3, bits 1 to 5 are 1. Unused data lanes and bit 0 stay 0.
- R6: `pin_jtdo` is 1 exactly when `jtag_sel` is 1 and `pin_trace[0]` is 0.
- R7: A low `sys_rst_n` leaves the stored configuration unchanged, so the pin outputs keep their values.
- R8: A write with `wr_en` high takes effect at the next rising edge of `clk`, even while `sys_rst_n` is low.
- R9: Suppose the edge that stores enable = 1 is edge k, with enable clear before it. Then `trace_clk` stays low through the clock-high phases after edges k, k+1 and k+2. It first follows `clk` in the high phase after edge k+3.
- R10: Suppose edge m stores enable = 0. Then `trace_clk` is low from the high phase after edge m+1 onward. A later enable restarts the full delay of R9.
- R11: `trace_clk` is 0 whenever `clk` is low.
- R12: Rewriting the mode while enable stays 1 does not interrupt or delay `trace_clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; the source of the trace clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low; does not affect the configuration |
| jtag_sel | input | 1 | 1 = JTAG debug interface active, 0 = serial-wire |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 3 | Bit 2 enable, bits 1:0 mode |
| pin_trace | output | 6 | Trace ownership: bit 0 single-wire, 1 clock, 2..5 data 0..3 |
| pin_jtdo | output | 1 | Single-wire pin owned by JTAG data-out |
| trace_clk | output | 1 | Gated trace port clock |

## Verification
The hardest case to reach is an enable that drops or returns while the delay counter is partway through its count. The trace clock then depends on the exact edge of each write relative to the negative-edge gate. Directed sequences cover clear-and-re-enable and mode rewrites with enable held. A long random phase then writes often enough, with system reset and the interface select toggling, that enables frequently last fewer than three cycles. Every high and low clock phase is compared against a bench model of the delay.

// File: rtl/trace_pin_pkg.sv
`timescale 1ns/1ps
package trace_pin_pkg;

  typedef enum logic [1:0] {
    MODE_ASYNC = 2'd0,
    MODE_SYNC1 = 2'd1,
    MODE_SYNC2 = 2'd2,
    MODE_SYNC4 = 2'd3
  } trace_mode_e;

  typedef struct packed {
    logic        en;
    trace_mode_e mode;
  } trace_cfg_t;

  localparam int CFG_W   = $bits(trace_cfg_t);
  localparam int PIN_SWO = 0;
  localparam int PIN_TCK = 1;
  localparam int PIN_D0  = 2;

  // number of data lanes a synchronous mode drives
  function automatic int lanes_for(trace_mode_e m);
    case (m)
      MODE_SYNC1: return 1;
      MODE_SYNC2: return 2;
      MODE_SYNC4: return 4;
      default:    return 0;
    endcase
  endfunction

endpackage

// File: rtl/tpc_cfg_reg.sv
`timescale 1ns/1ps
module tpc_cfg_reg
  import trace_pin_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             sys_rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output trace_cfg_t       cfg
);

  trace_cfg_t cfg_q;

  // power-on domain only; system reset deliberately not in the reset list
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= trace_cfg_t'(wr_data);
  end

  assign cfg = cfg_q;

  AST_SYSRST_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst_n && !wr_en) |=> $stable(cfg_q)); // R7
  AST_WRITE_UNDER_SYSRST: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst_n && wr_en) |=> (cfg_q == trace_cfg_t'($past(wr_data)))); // R8

endmodule

// File: rtl/tpc_pin_decode.sv
`timescale 1ns/1ps
module tpc_pin_decode
  import trace_pin_pkg::*;
#(
  parameter int DATA_LANES = 4,
  localparam int PIN_W = 2 + DATA_LANES
)(
  input  trace_cfg_t       cfg,
  input  logic             jtag_sel,
  output logic [PIN_W-1:0] own,
  output logic             jtdo_own
);

  logic sync_on;
  int   lane_cnt;

  always_comb begin
    sync_on  = cfg.en && (cfg.mode != MODE_ASYNC);
    lane_cnt = cfg.en ? lanes_for(cfg.mode) : 0;
  end

  assign own[PIN_SWO] = cfg.en && (cfg.mode == MODE_ASYNC);
  assign own[PIN_TCK] = sync_on;

  for (genvar i = 0; i < DATA_LANES; i++) begin : g_lane
    assign own[PIN_D0+i] = sync_on && (i < lane_cnt);
  end

  // released single-wire pin falls to JTAG data-out when that port is in use
  assign jtdo_own = jtag_sel && !own[PIN_SWO];

endmodule

// File: rtl/tpc_clk_enable.sv
`timescale 1ns/1ps
module tpc_clk_enable #(
  parameter int DELAY_CYCLES = 2,
  localparam int CNT_W = $clog2(DELAY_CYCLES + 1)
)(
  input  logic clk,
  input  logic por_n,
  input  logic en,
  output logic ready,
  output logic gated_clk
);

  logic [CNT_W-1:0] cnt_q;
  logic             gate_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                             cnt_q <= '0;
    else if (!en)                           cnt_q <= '0;
    else if (cnt_q != CNT_W'(DELAY_CYCLES)) cnt_q <= cnt_q + 1'b1;
  end

  assign ready = en && (cnt_q == CNT_W'(DELAY_CYCLES));

  // enable sampled on the falling edge: it only moves while clk is low
  always_ff @(negedge clk or negedge por_n) begin
    if (!por_n) gate_q <= 1'b0;
    else        gate_q <= ready;
  end

  assign gated_clk = clk & gate_q;

  AST_NO_READY_AT_ENABLE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(en) |-> !ready); // R9
  AST_READY_NEEDS_PRIOR_EN: assert property (@(posedge clk) disable iff (!por_n)
    $rose(ready) |-> $past(en)); // R9
  AST_DROP_ON_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
    $fell(en) |-> !ready); // R10

endmodule

// File: rtl/trace_pin_ctrl.sv
`timescale 1ns/1ps
module trace_pin_ctrl
  import trace_pin_pkg::*;
#(
  parameter int DATA_LANES   = 4,
  parameter int DELAY_CYCLES = 2,
  localparam int PIN_W = 2 + DATA_LANES
)(
  input  logic             clk,
  input  logic             por_n,
  input  logic             sys_rst_n,
  input  logic             jtag_sel,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [PIN_W-1:0] pin_trace,
  output logic             pin_jtdo,
  output logic             trace_clk
);

  trace_cfg_t cfg;
  logic       clk_ready;

  tpc_cfg_reg u_cfg (
    .clk       (clk),
    .por_n     (por_n),
    .sys_rst_n (sys_rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .cfg       (cfg)
  );

  tpc_pin_decode #(.DATA_LANES(DATA_LANES)) u_dec (
    .cfg      (cfg),
    .jtag_sel (jtag_sel),
    .own      (pin_trace),
    .jtdo_own (pin_jtdo)
  );

  tpc_clk_enable #(.DELAY_CYCLES(DELAY_CYCLES)) u_clk (
    .clk       (clk),
    .por_n     (por_n),
    .en        (cfg.en),
    .ready     (clk_ready),
    .gated_clk (trace_clk)
  );

  AST_OFF_NO_PINS: assert property (@(posedge clk) disable iff (!por_n)
    !cfg.en |-> (pin_trace == '0)); // R2
  AST_SWO_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0({pin_trace[PIN_SWO], pin_jtdo})); // R6
  AST_CLK_NEEDS_READY: assert property (@(posedge clk) disable iff (!por_n)
    $rose(clk_ready) |-> $past(cfg.en)); // R9

endmodule

// File: tb/trace_pin_ctrl_test.sv
`timescale 1ns/1ps
module trace_pin_ctrl_test;
  import trace_pin_pkg::*;

  localparam int D = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       por_n = 1'b0, sys_rst_n = 1'b0, jtag_sel = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_data = '0;
  logic [5:0] pin_trace;
  logic       pin_jtdo, trace_clk;

  trace_pin_ctrl uut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .jtag_sel(jtag_sel),
    .wr_en(wr_en), .wr_data(wr_data), .pin_trace(pin_trace),
    .pin_jtdo(pin_jtdo), .trace_clk(trace_clk)
  );

  int vectors = 0, errors = 0;
  logic [2:0] m_cfg = '0;
  int m_cnt = 0;
  bit m_ready = 0, m_prev = 0, done = 0;

  function automatic logic [6:0] exp_pins(logic [2:0] c, logic j);
    logic [5:0] p = '0;
    if (c[2]) case (c[1:0])
      2'd0: p[0] = 1'b1;
      2'd1: p[2:1] = 2'b11;
      2'd2: p[3:1] = 3'b111;
      default: p[5:1] = 5'b11111;
    endcase
    return {j & ~p[0], p};
  endfunction

  function automatic string pin_tag(logic [2:0] c);
    if (!c[2]) return "R2";
    if (c[1:0] == 2'd0) return "R3";
    if (c[1:0] == 2'd1) return "R4";
    return "R5";
  endfunction

  task automatic cycle(string ctx);
    logic [6:0] e;
    @(posedge clk);
    if (!por_n) begin
      m_cfg = '0; m_cnt = 0; m_ready = 0; m_prev = 0;
    end else begin
      m_prev = m_ready;
      m_cnt  = m_cfg[2] ? ((m_cnt < D) ? m_cnt + 1 : m_cnt) : 0;
      if (wr_en) m_cfg = wr_data;
      m_ready = m_cfg[2] && (m_cnt == D);
    end
    #5;
    e = exp_pins(m_cfg, jtag_sel);
    vectors++;
    if (pin_trace !== e[5:0]) begin
      errors++;
      $display("FAIL %s %s pin_trace actual %b expected %b", ctx, pin_tag(m_cfg), pin_trace, e[5:0]);
    end
    vectors++;
    if (pin_jtdo !== e[6]) begin
      errors++;
      $display("FAIL %s R6 pin_jtdo actual %b expected %b", ctx, pin_jtdo, e[6]);
    end
    vectors++;
    if (trace_clk !== m_prev) begin
      errors++;
      $display("FAIL %s R9 R10 trace_clk high phase actual %b expected %b", ctx, trace_clk, m_prev);
    end
    #10;
    vectors++;
    if (trace_clk !== 1'b0) begin
      errors++;
      $display("FAIL %s R11 trace_clk low phase actual %b expected 0", ctx, trace_clk);
    end
  endtask

  task automatic wr(logic [2:0] c, string ctx);
    wr_en = 1'b1; wr_data = c;
    cycle(ctx);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n, string ctx);
    for (int i = 0; i < n; i++) cycle(ctx);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    idle(3, "R1");
    por_n = 1'b1; sys_rst_n = 1'b1;
    idle(2, "R1");
    for (int j = 0; j < 2; j++) begin
      jtag_sel = j[0];
      for (int m = 0; m < 4; m++) begin
        wr({1'b1, 2'(m)}, "modes");
        idle(4, "modes");
        wr({1'b0, 2'(m)}, "R2");
        idle(2, "R2");
      end
    end
    jtag_sel = 1'b0;
    wr(3'b101, "R9");
    idle(6, "R9");
    wr(3'b001, "R10");
    idle(3, "R10");
    wr(3'b101, "R10 restart");
    wr(3'b001, "R10 short");
    wr(3'b101, "R10 restart");
    idle(5, "R10 restart");
    wr(3'b111, "R12");
    idle(4, "R12");
    wr(3'b100, "R12");
    wr(3'b110, "R12");
    idle(3, "R12");
    sys_rst_n = 1'b0;
    idle(5, "R7");
    wr(3'b010, "R8");
    idle(2, "R8");
    wr(3'b111, "R8");
    idle(4, "R8");
    sys_rst_n = 1'b1;
    idle(2, "R7");
    por_n = 1'b0;
    idle(2, "R1");
    por_n = 1'b1;
    idle(2, "R1");
    for (int i = 0; i < 4000; i++) begin
      wr_en     = ($urandom % 4) == 0;
      wr_data   = 3'($urandom);
      jtag_sel  = 1'($urandom);
      sys_rst_n = ($urandom % 8) != 0;
      if (($urandom % 300) == 0) por_n = 1'b0;
      cycle("random");
      por_n = 1'b1;
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule